// File: doc/BRIEF.md
# Multimode Test Register (Parallel / Scan / Pattern Generator / Signature Compactor)

This block is a small state register that can change what it is on every clock. Under a two-bit mode code it either clears itself synchronously, behaves as a bank of ordinary D flip-flops fed by the combinational logic ahead of it, becomes a serial shift chain for scan access, or runs as a linear feedback shift register. In the last mode, a sub-mode control chooses the flavour. With the parallel inputs masked to zero, it steps through a pseudo-random sequence that can drive logic under test. With the inputs left live, it folds each cycle's parallel input into its state and so builds a signature of the observed responses.

The default width is 3 bits. The feedback polynomial is x^3 + x^2 + 1: the XOR of bits 2 and 1 enters bit 0, and every other bit takes the bit below it. The chain moves from bit 0 towards the top bit, and the top bit is always the serial output. The all-zero state does not advance in generator use, so a seed is loaded through a parallel load or a scan shift before test mode begins.

Top module: `multimode_test_reg`

## Requirements
- R1: With `mode_sel` = 2'b00 (clear), every bit of `par_out` is 0 after the next rising clock edge, whatever the other inputs are.
- R2: With `mode_sel` = 2'b01 (load), `par_out` takes the value of `par_in` at the next rising edge.
- R3: With `mode_sel` = 2'b10 (shift), at each edge bit 0 takes `ser_in` and bit i takes the old bit i-1, so new `par_out` = {old `par_out`[1:0], `ser_in`}.
- R4: With `mode_sel` = 2'b11 (self-test) and `pattern_only` = 1, the next state is {q[1:0], q[2] ^ q[1]}, and `par_in` has no effect on it.
- R5: With `mode_sel` = 2'b11 and `pattern_only` = 0, the next state is {q[1:0], q[2] ^ q[1]} XOR `par_in` (bit-wise), so different input streams leave different signatures.
- R6: From any nonzero seed, generator stepping (R4) visits 7 distinct states and returns to the seed after exactly 7 steps. From seed 3'b001 the order is 001, 010, 101, 011, 111, 110, 100.
- R7: In generator stepping, the all-zero state stays all-zero.
- R8: `ser_out` always equals `par_out`[2] (the top bit), in every mode.
- R9: `pattern_only` has no effect outside mode 2'b11. In load mode with `pattern_only` = 1, `par_in` is still captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| mode_sel | input | 2 | 00 clear, 01 load, 10 shift, 11 self-test |
| pattern_only | input | 1 | In self-test: 1 masks `par_in` (generator), 0 folds it in (compactor) |
| par_in | input | 3 | Parallel data from the logic under test |
| ser_in | input | 1 | Serial data entering bit 0 in shift mode |
| par_out | output | 3 | Register state |
| ser_out | output | 1 | Top bit of the state |

## Verification
Generator stepping is run from two different seeds, with `par_in` held at all ones. This separates a correct tap choice from a wrong one, which would give a different order or a shorter cycle. It also shows that the masked input is truly ignored. The compactor is fed two input streams that differ in a single cycle. Their final signatures must differ, and each signature must match a reference fold, which exposes a dropped or misplaced input XOR. Shift mode is loaded with an asymmetric bit pattern so that a reversed chain direction shows. The zero lock-up and the load under `pattern_only` = 1 show whether the sub-mode leaks out of its own mode.

// File: rtl/mtr_pkg.sv
package mtr_pkg;

    typedef enum logic [1:0] {
        MODE_CLEAR    = 2'b00,
        MODE_LOAD     = 2'b01,
        MODE_SHIFT    = 2'b10,
        MODE_SELFTEST = 2'b11
    } mtr_mode_e;

    typedef struct packed {
        mtr_mode_e mode;
        logic      pattern_only;
    } mtr_ctrl_t;

    // Per-bit source selection derived from the control word
    typedef enum logic [1:0] {
        SRC_ZERO  = 2'b00,
        SRC_PAR   = 2'b01,
        SRC_CHAIN = 2'b10,
        SRC_MIX   = 2'b11
    } mtr_src_e;

    function automatic mtr_src_e src_of(input mtr_ctrl_t c);
        unique case (c.mode)
            MODE_CLEAR: return SRC_ZERO;
            MODE_LOAD:  return SRC_PAR;
            MODE_SHIFT: return SRC_CHAIN;
            default:    return c.pattern_only ? SRC_CHAIN : SRC_MIX;
        endcase
    endfunction

endpackage

// File: rtl/mtr_feedback.sv
module mtr_feedback #(
    parameter int          W    = 3,
    parameter logic [W-1:0] TAPS = 3'b110
) (
    input  logic [W-1:0] state,
    output logic         fb
);
    // Parity of the tapped bits
    assign fb = ^(state & TAPS);
endmodule

// File: rtl/mtr_stage_mux.sv
module mtr_stage_mux
    import mtr_pkg::*;
#(
    parameter int W = 3
) (
    input  mtr_ctrl_t    ctrl,
    input  logic [W-1:0] state,
    input  logic [W-1:0] par_in,
    input  logic         ser_in,
    input  logic         fb,
    output logic [W-1:0] nxt
);
    mtr_src_e src;
    logic     selftest;

    assign src      = src_of(ctrl);
    assign selftest = (ctrl.mode == MODE_SELFTEST);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic chain_bit;
        if (i == 0) begin : g_head
            // Head of chain: serial input in shift mode, feedback in self-test
            assign chain_bit = selftest ? fb : ser_in;
        end else begin : g_body
            assign chain_bit = state[i-1];
        end

        always_comb begin
            unique case (src)
                SRC_ZERO:  nxt[i] = 1'b0;
                SRC_PAR:   nxt[i] = par_in[i];
                SRC_CHAIN: nxt[i] = chain_bit;
                default:   nxt[i] = chain_bit ^ par_in[i];
            endcase
        end
    end
endmodule

// File: rtl/mtr_state_reg.sv
module mtr_state_reg #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic [W-1:0] nxt,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        q <= nxt;
    end
endmodule

// File: rtl/multimode_test_reg.sv
module multimode_test_reg
    import mtr_pkg::*;
#(
    parameter int           W    = 3,
    parameter logic [W-1:0] TAPS = 3'b110
) (
    input  logic         clk,
    input  logic [1:0]   mode_sel,
    input  logic         pattern_only,
    input  logic [W-1:0] par_in,
    input  logic         ser_in,
    output logic [W-1:0] par_out,
    output logic         ser_out
);
    mtr_ctrl_t    ctrl;
    logic [W-1:0] state;
    logic [W-1:0] nxt;
    logic         fb;

    assign ctrl.mode         = mtr_mode_e'(mode_sel);
    assign ctrl.pattern_only = pattern_only;

    mtr_feedback #(.W(W), .TAPS(TAPS)) u_fb (
        .state (state),
        .fb    (fb)
    );

    mtr_stage_mux #(.W(W)) u_mux (
        .ctrl   (ctrl),
        .state  (state),
        .par_in (par_in),
        .ser_in (ser_in),
        .fb     (fb),
        .nxt    (nxt)
    );

    mtr_state_reg #(.W(W)) u_reg (
        .clk (clk),
        .nxt (nxt),
        .q   (state)
    );

    assign par_out = state;
    assign ser_out = state[W-1];
endmodule

// File: rtl/mtr_checker.sv
module mtr_checker #(
    parameter int           W    = 3,
    parameter logic [W-1:0] TAPS = 3'b110
) (
    input logic         clk,
    input logic [1:0]   mode_sel,
    input logic         pattern_only,
    input logic [W-1:0] par_in,
    input logic         ser_in,
    input logic [W-1:0] par_out
);
    // Checks stay off until a clear has been seen, so state is defined
    logic primed = 1'b0;
    always_ff @(posedge clk) begin
        primed <= primed | (mode_sel == 2'b00);
    end

    assert_clear_R1: assert property (@(posedge clk) disable iff (!primed)
        mode_sel == 2'b00 |=> par_out == '0);

    assert_load_R2: assert property (@(posedge clk) disable iff (!primed)
        mode_sel == 2'b01 |=> par_out == $past(par_in));

    assert_shift_R3: assert property (@(posedge clk) disable iff (!primed)
        mode_sel == 2'b10 |=> par_out == {$past(par_out[W-2:0]), $past(ser_in)});

    assert_generate_R4: assert property (@(posedge clk) disable iff (!primed)
        (mode_sel == 2'b11 && pattern_only) |=>
            par_out == {$past(par_out[W-2:0]), ^($past(par_out) & TAPS)});

    assert_compact_R5: assert property (@(posedge clk) disable iff (!primed)
        (mode_sel == 2'b11 && !pattern_only) |=>
            par_out == ({$past(par_out[W-2:0]), ^($past(par_out) & TAPS)} ^ $past(par_in)));

    assert_zero_lock_R7: assert property (@(posedge clk) disable iff (!primed)
        (mode_sel == 2'b11 && pattern_only && par_out == '0) |=> par_out == '0);
endmodule

bind multimode_test_reg mtr_checker #(.W(W), .TAPS(TAPS)) u_chk (
    .clk          (clk),
    .mode_sel     (mode_sel),
    .pattern_only (pattern_only),
    .par_in       (par_in),
    .ser_in       (ser_in),
    .par_out      (par_out)
);

// File: tb/multimode_test_reg_bench.sv
`timescale 1ns/1ps
module multimode_test_reg_bench;
    logic       clk = 1'b0;
    logic [1:0] mode_sel = 2'b00;
    logic       pattern_only = 1'b0;
    logic [2:0] par_in = 3'b000;
    logic       ser_in = 1'b0;
    logic [2:0] par_out;
    logic       ser_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    multimode_test_reg u_multimode_test_reg (
        .clk          (clk),
        .mode_sel     (mode_sel),
        .pattern_only (pattern_only),
        .par_in       (par_in),
        .ser_in       (ser_in),
        .par_out      (par_out),
        .ser_out      (ser_out)
    );

    function automatic logic [2:0] gen_step(input logic [2:0] q);
        return {q[1:0], q[2] ^ q[1]};
    endfunction

    task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // Drive at the falling edge, let one rising edge pass, sample 1 ns later
    task automatic cyc(input logic [1:0] m, input logic po, input logic [2:0] d, input logic si);
        @(negedge clk);
        mode_sel = m; pattern_only = po; par_in = d; ser_in = si;
        @(posedge clk);
        #1;
    endtask

    task automatic t_clear;
        cyc(2'b01, 1'b0, 3'b111, 1'b1);
        cyc(2'b00, 1'b1, 3'b111, 1'b1);
        check("R1 clear", par_out, 3'b000);
        check("R8 ser_out after clear", {2'b00, ser_out}, 3'b000);
    endtask

    task automatic t_load;
        cyc(2'b01, 1'b0, 3'b101, 1'b0);
        check("R2 load 101", par_out, 3'b101);
        cyc(2'b01, 1'b0, 3'b010, 1'b1);
        check("R2 load 010", par_out, 3'b010);
        cyc(2'b01, 1'b1, 3'b110, 1'b0);
        check("R9 load with pattern_only", par_out, 3'b110);
        check("R8 ser_out after load", {2'b00, ser_out}, 3'b001);
    endtask

    task automatic t_shift;
        cyc(2'b00, 1'b0, 3'b000, 1'b0);
        cyc(2'b10, 1'b0, 3'b111, 1'b1);
        check("R3 shift 1", par_out, 3'b001);
        cyc(2'b10, 1'b0, 3'b111, 1'b1);
        check("R3 shift 2", par_out, 3'b011);
        cyc(2'b10, 1'b0, 3'b000, 1'b0);
        check("R3 shift 3", par_out, 3'b110);
        check("R8 ser_out in shift", {2'b00, ser_out}, 3'b001);
        cyc(2'b10, 1'b1, 3'b000, 1'b0);
        check("R3 shift 4 (R9 pattern_only ignored)", par_out, 3'b100);
    endtask

    task automatic t_generate(input logic [2:0] seed);
        logic [2:0] exp = seed;
        logic [7:0] seen = '0;
        cyc(2'b01, 1'b0, seed, 1'b0);
        for (int k = 1; k <= 7; k++) begin
            seen[exp] = 1'b1;
            exp = gen_step(exp);
            cyc(2'b11, 1'b1, 3'b111, 1'b1);
            check("R4 generator step", par_out, exp);
            if (k < 7) check("R6 no early repeat", {2'b00, seen[par_out]}, 3'b000);
        end
        check("R6 back to seed after 7", par_out, seed);
    endtask

    task automatic t_zero_lock;
        cyc(2'b00, 1'b0, 3'b000, 1'b0);
        for (int k = 0; k < 3; k++) begin
            cyc(2'b11, 1'b1, 3'b111, 1'b1);
            check("R7 zero stays zero", par_out, 3'b000);
        end
    endtask

    task automatic t_compact;
        logic [2:0] sa = 3'b000;
        logic [2:0] sb = 3'b000;
        logic [2:0] stream [5] = '{3'b101, 3'b011, 3'b000, 3'b110, 3'b001};
        cyc(2'b00, 1'b0, 3'b000, 1'b0);
        for (int k = 0; k < 5; k++) begin
            sa = gen_step(sa) ^ stream[k];
            cyc(2'b11, 1'b0, stream[k], 1'b0);
            check("R5 compactor step", par_out, sa);
        end
        cyc(2'b00, 1'b0, 3'b000, 1'b0);
        for (int k = 0; k < 5; k++) begin
            logic [2:0] d = (k == 2) ? 3'b010 : stream[k];
            sb = gen_step(sb) ^ d;
            cyc(2'b11, 1'b0, d, 1'b0);
        end
        check("R5 second signature", par_out, sb);
        check("R5 signatures differ", {2'b00, (sa != sb)}, 3'b001);
    endtask

    initial begin
        #100000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        cyc(2'b00, 1'b0, 3'b000, 1'b0);
        check("R1 reset state", par_out, 3'b000);
        t_clear();
        t_load();
        t_shift();
        t_generate(3'b001);
        t_generate(3'b110);
        t_zero_lock();
        t_compact();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule